// File: doc/BRIEF.md
# PWM Controller Register Bank

This block is the configuration store of a multi-channel PWM controller. A bus front end hands it single-cycle write and read strobes with an 8-bit byte address and 8-bit data. The block keeps two mode registers, a chip-wide prescale byte and four bytes per channel that give a 12-bit turn-on count, a 12-bit turn-off count and the two force flags. It presents all of this, decoded, to the PWM engine.

Two address behaviours go beyond plain storage. A group of four broadcast addresses writes one byte into the matching register of every channel in the same cycle. Reads of that group return zero. The prescale byte can only change while the sleep bit is set, so the counter clock never switches rate while outputs run.

Top module: `pwm_reg_bank`

## Requirements
- R1: After reset, mode register A reads 0x10 (sleep set), mode register B reads 0x04, prescale reads 0x1E, and every channel has turn-on count 0, turn-off count 0, force-on clear and force-off set.
- R2: Channel n (0 to NCH-1) holds four bytes at 0x06+4n (on count bits 7:0), 0x07+4n (on high byte), 0x08+4n (off count bits 7:0) and 0x09+4n (off high byte). Each byte reads back what was written to it.
- R3: In both high bytes, bits 3:0 are count bits 11:8 and bit 4 is the force flag (force-on in the on byte, force-off in the off byte). Bits 7:5 are not stored and read as 0.
- R4: A write to 0xFA, 0xFB, 0xFC or 0xFD writes the on-low, on-high, off-low or off-high byte of every channel at once.
- R5: A read of 0xFA to 0xFD returns 0.
- R6: A write to the prescale byte at 0xFE takes effect when mode register A bit 4 (sleep) is set at the time of the write.
- R7: A write to 0xFE while sleep is clear is ignored, and the stored prescale keeps its value.
- R8: Mode registers A (0x00) and B (0x01) are full 8-bit read/write. The sleep output is A bit 4, the invert output is B bit 4, and the totem-pole output is B bit 2.
- R9: Addresses 0x02 to 0x05, 0x06+4·NCH to 0xF9 and 0xFF are unmapped. Writes to them change nothing, and reads return 0.
- R10: Read data appears on rdata in the cycle after rd_en and holds while rd_en is low. Register outputs change in the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ch_on | output | 12·NCH | Turn-on counts, channel n at bits 12n+11:12n |
| ch_off | output | 12·NCH | Turn-off counts, same packing |
| ch_full_on | output | NCH | Force-on flag per channel |
| ch_full_off | output | NCH | Force-off flag per channel |
| prescale | output | 8 | Prescale byte |
| sleep | output | 1 | Sleep bit |
| invert | output | 1 | Output invert select |
| totem | output | 1 | Totem-pole drive select (0 = open-drain) |

## Verification
A decode fault or a wrong stored byte is visible on the per-channel output buses in the cycle after the write that caused it. It is also visible on rdata one cycle after the next read of that byte. For this reason the bench compares every output against its model after every operation. A bad prescale gate shows only when a prescale write meets the wrong sleep state, so sleep is toggled often during the random phase. Broadcast faults show on all channels at once, and a leak of channel state onto broadcast reads shows on the first read of 0xFA to 0xFD.

// File: rtl/pwm_regs_pkg.sv
package pwm_regs_pkg;
  localparam int CNT_W  = 12;
  localparam int BYTE_W = 8;

  localparam logic [7:0] A_MODE_A  = 8'h00;
  localparam logic [7:0] A_MODE_B  = 8'h01;
  localparam logic [7:0] A_CH_BASE = 8'h06;
  localparam logic [7:0] A_BC_FIRST = 8'hFA;
  localparam logic [7:0] A_BC_LAST  = 8'hFD;
  localparam logic [7:0] A_PRESC   = 8'hFE;

  localparam int SLEEP_BIT = 4;
  localparam int INV_BIT   = 4;
  localparam int TOTEM_BIT = 2;
  localparam int FLAG_BIT  = 4;

  localparam logic [7:0] MODE_A_RST = 8'h10;
  localparam logic [7:0] MODE_B_RST = 8'h04;
  localparam logic [7:0] PRESC_RST  = 8'h1E;

  typedef enum logic [2:0] {
    RK_NONE, RK_MODE_A, RK_MODE_B, RK_CHAN, RK_BCAST, RK_PRESC
  } reg_kind_e;

  typedef enum logic [1:0] {
    F_ON_LO, F_ON_HI, F_OFF_LO, F_OFF_HI
  } chan_field_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [5:0]  chan;
    chan_field_e field;
  } reg_sel_t;

  function automatic reg_sel_t decode_addr(input logic [7:0] a, input int nch);
    reg_sel_t s;
    logic [7:0] coff;
    logic [7:0] boff;
    s.kind  = RK_NONE;
    s.chan  = '0;
    s.field = F_ON_LO;
    coff = a - A_CH_BASE;
    boff = a - A_BC_FIRST;
    if (a == A_MODE_A)                        s.kind = RK_MODE_A;
    else if (a == A_MODE_B)                   s.kind = RK_MODE_B;
    else if (a == A_PRESC)                    s.kind = RK_PRESC;
    else if (a >= A_BC_FIRST && a <= A_BC_LAST) begin
      s.kind  = RK_BCAST;
      s.field = chan_field_e'(boff[1:0]);
    end else if (a >= A_CH_BASE && int'(coff) < 4 * nch) begin
      s.kind  = RK_CHAN;
      s.chan  = coff[7:2];
      s.field = chan_field_e'(coff[1:0]);
    end
    return s;
  endfunction

  function automatic logic [7:0] pack_hi(input logic flag, input logic [3:0] nib);
    return {3'b000, flag, nib};
  endfunction

  function automatic logic presc_write_ok(input logic [7:0] mode_a);
    return mode_a[SLEEP_BIT];
  endfunction
endpackage

// File: rtl/pwm_addr_decode.sv
module pwm_addr_decode
  import pwm_regs_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic [7:0] addr,
  output reg_sel_t   sel
);
  always_comb sel = decode_addr(addr, NCH);
endmodule

// File: rtl/pwm_chan_regs.sv
module pwm_chan_regs
  import pwm_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  chan_field_e       field,
  input  logic [7:0]        wdata,
  output logic [CNT_W-1:0]  on_cnt,
  output logic [CNT_W-1:0]  off_cnt,
  output logic              full_on,
  output logic              full_off,
  output logic [3:0][7:0]   rd_bytes
);
  logic [7:0] on_lo, off_lo;
  logic [4:0] on_hi, off_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_lo  <= '0;
      on_hi  <= '0;
      off_lo <= '0;
      off_hi <= 5'h10;
    end else if (we) begin
      case (field)
        F_ON_LO:  on_lo  <= wdata;
        F_ON_HI:  on_hi  <= wdata[4:0];
        F_OFF_LO: off_lo <= wdata;
        F_OFF_HI: off_hi <= wdata[4:0];
        default:  ;
      endcase
    end
  end

  assign on_cnt   = {on_hi[3:0], on_lo};
  assign off_cnt  = {off_hi[3:0], off_lo};
  assign full_on  = on_hi[FLAG_BIT];
  assign full_off = off_hi[FLAG_BIT];

  always_comb begin
    rd_bytes[F_ON_LO]  = on_lo;
    rd_bytes[F_ON_HI]  = pack_hi(on_hi[FLAG_BIT], on_hi[3:0]);
    rd_bytes[F_OFF_LO] = off_lo;
    rd_bytes[F_OFF_HI] = pack_hi(off_hi[FLAG_BIT], off_hi[3:0]);
  end
endmodule

// File: rtl/pwm_ctrl_regs.sv
module pwm_ctrl_regs
  import pwm_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_mode_a,
  input  logic       we_mode_b,
  input  logic       we_presc,
  input  logic [7:0] wdata,
  output logic [7:0] mode_a,
  output logic [7:0] mode_b,
  output logic [7:0] presc,
  output logic       presc_accept,
  output logic       presc_block
);
  assign presc_accept = we_presc &&  presc_write_ok(mode_a);
  assign presc_block  = we_presc && !presc_write_ok(mode_a);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_a <= MODE_A_RST;
      mode_b <= MODE_B_RST;
      presc  <= PRESC_RST;
    end else begin
      if (we_mode_a)    mode_a <= wdata;
      if (we_mode_b)    mode_b <= wdata;
      if (presc_accept) presc  <= wdata;
    end
  end
endmodule

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank
  import pwm_regs_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [7:0]         addr,
  input  logic [7:0]         wdata,
  output logic [7:0]         rdata,
  output logic [NCH*CNT_W-1:0] ch_on,
  output logic [NCH*CNT_W-1:0] ch_off,
  output logic [NCH-1:0]     ch_full_on,
  output logic [NCH-1:0]     ch_full_off,
  output logic [7:0]         prescale,
  output logic               sleep,
  output logic               invert,
  output logic               totem
);
  reg_sel_t sel;
  logic [7:0] mode_a, mode_b;
  logic presc_accept, presc_block, bcast_we;
  logic [NCH-1:0][3:0][7:0] chan_rd;
  logic [7:0] rd_val;

  pwm_addr_decode #(.NCH(NCH)) u_dec (.addr(addr), .sel(sel));

  assign bcast_we = wr_en && sel.kind == RK_BCAST;

  pwm_ctrl_regs u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .we_mode_a(wr_en && sel.kind == RK_MODE_A),
    .we_mode_b(wr_en && sel.kind == RK_MODE_B),
    .we_presc (wr_en && sel.kind == RK_PRESC),
    .wdata(wdata), .mode_a(mode_a), .mode_b(mode_b), .presc(prescale),
    .presc_accept(presc_accept), .presc_block(presc_block)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic ch_we;
    assign ch_we = bcast_we || (wr_en && sel.kind == RK_CHAN && sel.chan == 6'(i));
    pwm_chan_regs u_ch (
      .clk(clk), .rst_n(rst_n), .we(ch_we), .field(sel.field), .wdata(wdata),
      .on_cnt(ch_on[i*CNT_W +: CNT_W]), .off_cnt(ch_off[i*CNT_W +: CNT_W]),
      .full_on(ch_full_on[i]), .full_off(ch_full_off[i]), .rd_bytes(chan_rd[i])
    );
  end

  always_comb begin
    rd_val = '0;
    case (sel.kind)
      RK_MODE_A: rd_val = mode_a;
      RK_MODE_B: rd_val = mode_b;
      RK_PRESC:  rd_val = prescale;
      RK_CHAN: begin
        for (int i = 0; i < NCH; i++)
          if (sel.chan == 6'(i)) rd_val = chan_rd[i][sel.field];
      end
      default:   rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_val;
  end

  assign sleep  = mode_a[SLEEP_BIT];
  assign invert = mode_b[INV_BIT];
  assign totem  = mode_b[TOTEM_BIT];
endmodule

// File: rtl/pwm_reg_bank_chk.sv
module pwm_reg_bank_chk
  import pwm_regs_pkg::*;
#(
  parameter int NCH = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [7:0]           addr,
  input logic [7:0]           wdata,
  input logic [7:0]           rdata,
  input logic [NCH*CNT_W-1:0] ch_on,
  input logic [NCH*CNT_W-1:0] ch_off,
  input logic [NCH-1:0]       ch_full_off,
  input logic [7:0]           prescale,
  input logic                 sleep,
  input logic                 invert,
  input logic                 totem,
  input logic                 presc_block
);
  p_rst_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (sleep && (&ch_full_off) && prescale == PRESC_RST));

  p_presc_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PRESC && sleep) |=> prescale == $past(wdata));

  p_presc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_PRESC && !sleep) |=> $stable(prescale));

  p_block_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    presc_block |=> $stable(prescale));

  p_bcast_rd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr >= A_BC_FIRST && addr <= A_BC_LAST) |=> rdata == 8'h00);

  p_unmap_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 8'hFF) |=> rdata == 8'h00);

  p_mode_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == A_MODE_B) |=> (invert == $past(wdata[INV_BIT]) && totem == $past(wdata[TOTEM_BIT])));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  for (genvar i = 0; i < NCH; i++) begin : g_bc
    p_bcast_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_BC_FIRST) |=> ch_on[i*CNT_W +: 8] == $past(wdata));
    p_bcast_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 8'hFC) |=> ch_off[i*CNT_W +: 8] == $past(wdata));
  end
endmodule

bind pwm_reg_bank pwm_reg_bank_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .ch_on(ch_on), .ch_off(ch_off),
  .ch_full_off(ch_full_off), .prescale(prescale), .sleep(sleep),
  .invert(invert), .totem(totem), .presc_block(presc_block)
);

// File: tb/tb_pwm_reg_bank.sv
module tb_pwm_reg_bank;
  localparam int NCH = 16;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic [NCH*12-1:0] ch_on, ch_off;
  logic [NCH-1:0] ch_full_on, ch_full_off;
  logic [7:0] prescale;
  logic sleep, invert, totem;

  int n_checks = 0;
  int n_fails = 0;

  logic [7:0] m_ma, m_mb, m_ps;
  logic [7:0] m_onl [NCH];
  logic [4:0] m_onh [NCH];
  logic [7:0] m_offl [NCH];
  logic [4:0] m_offh [NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_reg_bank #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ch_on(ch_on), .ch_off(ch_off),
    .ch_full_on(ch_full_on), .ch_full_off(ch_full_off), .prescale(prescale),
    .sleep(sleep), .invert(invert), .totem(totem)
  );

  task automatic model_reset();
    m_ma = 8'h10; m_mb = 8'h04; m_ps = 8'h1E;
    for (int i = 0; i < NCH; i++) begin
      m_onl[i] = 0; m_onh[i] = 0; m_offl[i] = 0; m_offh[i] = 5'h10;
    end
  endtask

  function automatic logic is_chan(input logic [7:0] a);
    return a >= 8'h06 && int'(a) < 6 + 4 * NCH;
  endfunction

  task automatic model_field(input int ch, input int f, input logic [7:0] d);
    case (f)
      0: m_onl[ch] = d;
      1: m_onh[ch] = d[4:0];
      2: m_offl[ch] = d;
      default: m_offh[ch] = d[4:0];
    endcase
  endtask

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h00) m_ma = d;
    else if (a == 8'h01) m_mb = d;
    else if (a == 8'hFE) begin
      if (m_ma[4]) m_ps = d;
    end else if (a >= 8'hFA && a <= 8'hFD) begin
      for (int i = 0; i < NCH; i++) model_field(i, int'(a) - 250, d);
    end else if (is_chan(a)) model_field((int'(a) - 6) / 4, (int'(a) - 6) % 4, d);
  endtask

  function automatic logic [7:0] model_read(input logic [7:0] a);
    int ch, f;
    if (a == 8'h00) return m_ma;
    if (a == 8'h01) return m_mb;
    if (a == 8'hFE) return m_ps;
    if (!is_chan(a)) return 8'h00;
    ch = (int'(a) - 6) / 4;
    f  = (int'(a) - 6) % 4;
    case (f)
      0: return m_onl[ch];
      1: return {3'b000, m_onh[ch]};
      2: return m_offl[ch];
      default: return {3'b000, m_offh[ch]};
    endcase
  endfunction

  task automatic check_outs(input string tag);
    logic [NCH*12-1:0] e_on, e_off;
    logic [NCH-1:0] e_fon, e_foff;
    logic ok;
    for (int i = 0; i < NCH; i++) begin
      e_on[i*12 +: 12]  = {m_onh[i][3:0], m_onl[i]};
      e_off[i*12 +: 12] = {m_offh[i][3:0], m_offl[i]};
      e_fon[i]  = m_onh[i][4];
      e_foff[i] = m_offh[i][4];
    end
    ok = (ch_on === e_on) && (ch_off === e_off) && (ch_full_on === e_fon) &&
         (ch_full_off === e_foff) && (prescale === m_ps) && (sleep === m_ma[4]) &&
         (invert === m_mb[4]) && (totem === m_mb[2]);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s outputs: on=%h off=%h fon=%h foff=%h ps=%h s/i/t=%b%b%b exp on=%h off=%h fon=%h foff=%h ps=%h s/i/t=%b%b%b",
        tag, ch_on, ch_off, ch_full_on, ch_full_off, prescale, sleep, invert, totem,
        e_on, e_off, e_fon, e_foff, m_ps, m_ma[4], m_mb[4], m_mb[2]);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
    check_outs(tag);
  endtask

  task automatic do_read(input logic [7:0] a, input string tag);
    logic [7:0] e;
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    e = model_read(a);
    n_checks++;
    if (rdata !== e) begin
      n_fails++;
      $display("FAIL %s read addr %h: got %h expected %h", tag, a, rdata, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [7:0] held;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check_outs("R1 reset outputs");
    do_read(8'h00, "R1 mode A reset");
    do_read(8'h01, "R1 mode B reset");
    do_read(8'hFE, "R1 prescale reset");
    do_read(8'h09, "R1 ch0 off high reset");

    do_write(8'hFE, 8'h55, "R6 prescale while asleep");
    do_write(8'h00, 8'h00, "R8 wake");
    do_write(8'hFE, 8'hAA, "R7 prescale ignored while awake");
    do_read(8'hFE, "R7 prescale unchanged");
    do_write(8'h00, 8'h10, "R8 sleep again");
    do_write(8'hFE, 8'h03, "R6 prescale reloaded");

    do_write(8'h01, 8'h10, "R8 invert on, open-drain");
    do_write(8'h01, 8'h04, "R8 totem on");

    do_write(8'h07 + 8'd20, 8'hFF, "R3 on high byte mask");
    do_read(8'h07 + 8'd20, "R3 on high read 0x1F");
    do_write(8'h06 + 8'd60, 8'hC3, "R2 last channel on low");
    do_read(8'h06 + 8'd60, "R2 last channel read");

    do_write(8'hFA, 8'h5A, "R4 broadcast on low");
    do_write(8'hFB, 8'h1F, "R4 broadcast on high");
    do_write(8'hFC, 8'hA5, "R4 broadcast off low");
    do_write(8'hFD, 8'h07, "R4 broadcast off high");
    for (int a = 8'hFA; a <= 8'hFD; a++) do_read(8'(a), "R5 broadcast read zero");

    do_write(8'h02, 8'hFF, "R9 unmapped low write");
    do_write(8'h46, 8'hFF, "R9 unmapped above channels");
    do_write(8'hF9, 8'hFF, "R9 unmapped F9");
    do_write(8'hFF, 8'hFF, "R9 unmapped FF");
    do_read(8'h05, "R9 read 05");
    do_read(8'h46, "R9 read 46");
    do_read(8'hFF, "R9 read FF");

    do_read(8'h00, "R10 read mode A");
    held = rdata;
    repeat (3) @(negedge clk);
    n_checks++;
    if (rdata !== held) begin
      n_fails++;
      $display("FAIL R10 rdata hold: got %h expected %h", rdata, held);
    end

    for (int k = 0; k < 600; k++) begin
      logic [7:0] a;
      int r;
      r = int'($urandom % 10);
      case (r)
        0, 1, 2, 3, 4: a = 8'(8'h06 + $urandom % (4 * NCH));
        5:    a = 8'(8'hFA + $urandom % 4);
        6, 7: a = 8'hFE;
        8:    a = 8'h00;
        default: a = 8'($urandom);
      endcase
      if ($urandom % 2 == 0) do_write(a, 8'($urandom), "R2 R4 R6 R7 R9 random write");
      else                   do_read(a, "R2 R5 R9 R10 random read");
    end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end
endmodule